// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a 32-bit linear address. A logical address is a 16-bit selector held in one of several segment registers, plus a 32-bit offset. Each segment register has a hidden descriptor cache. Writing a segment register in protected mode starts a fetch of the 8-byte descriptor through a simple memory read port, from either the global or the local table base. Translations read only the cached base, limit, privilege and presence, so no table access happens on the translation path.

A translation request names a segment register and an offset. One cycle after it is accepted, the block returns the linear address and a fault flag. Protected-mode faults come from four causes: a register never loaded, a descriptor that is not present, an offset past the effective limit (the limit is scaled to 4 KB units when granularity is set), and a privilege mismatch. With real-mode select high, the unit adds the selector shifted by four to a 16-bit offset and wraps the result to 20 bits. Loads in that mode take effect at once, with no memory access.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid and mem_req are low, and ld_ready and tr_ready are high.
- R2: A protected-mode load of selector S reads two 32-bit words, lower address first. The first word is at base + {S[15:3],3'b000} and the second at that address + 4. The base is ltab_base when S[2] is 1 and gtab_base when S[2] is 0. mem_addr holds steady while mem_req is high and mem_rvalid is low.
- R3: The descriptor is decoded from low word L and high word H. Base = {H[31:24], H[7:0], L[31:16]}. Limit = {H[19:16], L[15:0]}. Granularity is H[23], privilege level is H[14:13] and present is H[15].
- R4: In protected mode, an accepted translation that does not fault returns out_lin = base + offset, with out_valid high in the next cycle only.
- R5: With granularity clear, an offset above the 20-bit limit faults, and an offset equal to the limit does not.
- R6: With granularity set, the effective limit is {limit, 12'hFFF}.
- R7: A translation through a register never loaded in protected mode faults. So does one whose descriptor has present clear.
- R8: The current level is bits 1:0 of the selector in segment register 0. A protected-mode translation faults when the larger of that level and bits 1:0 of the used register's selector exceeds the descriptor privilege level.
- R9: Translations make no memory reads. A change of the table bases has no effect until the register is reloaded, and a reload makes the new descriptor take effect.
- R10: While a register's descriptor fetch is in progress, tr_ready is low for that register and high for the others.
- R11: In real mode, a load takes effect at once with no memory read. A translation returns ({selector,4'h0} + offset[15:0]) mod 2^20, with offset bits 31:16 ignored and no fault.
- R12: A faulting translation returns out_lin = 0.
- R13: ld_ready is low while a descriptor fetch is in progress, and loads are accepted only when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| real_mode | input | 1 | High selects shift-and-add translation |
| gtab_base | input | 32 | Global descriptor table base address |
| ltab_base | input | 32 | Local descriptor table base address |
| ld_valid | input | 1 | Segment register load request |
| ld_ready | output | 1 | Load can be accepted |
| ld_seg | input | SEGW | Segment register to load |
| ld_sel | input | 16 | Selector value to load |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| tr_valid | input | 1 | Translation request |
| tr_ready | output | 1 | Translation can be accepted |
| tr_seg | input | SEGW | Segment register used |
| tr_off | input | 32 | Offset |
| out_valid | output | 1 | Result valid |
| out_lin | output | 32 | Linear address, zero on fault |
| out_fault | output | 1 | Translation rejected |

## Verification
The bench builds the unit with the default four segment registers. Every register is loaded: one from the local table, one never loaded, and one whose descriptor is not present. A reload of the register that carries the current level raises that level and lowers it again. The memory model answers each read after a gap, so a fetch stays in flight for several cycles. That gap brings the stall of one register and the pass-through of another within reach, along with limit edges on both granularities and real-mode wrap above 1 MB.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 4,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            real_mode,
  input  logic [31:0]     gtab_base,
  input  logic [31:0]     ltab_base,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [SEGW-1:0] ld_seg,
  input  logic [15:0]     ld_sel,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  input  logic            tr_valid,
  output logic            tr_ready,
  input  logic [SEGW-1:0] tr_seg,
  input  logic [31:0]     tr_off,
  output logic            out_valid,
  output logic [31:0]     out_lin,
  output logic            out_fault
);

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_t;

  fstate_t         fst;
  logic [SEGW-1:0] f_seg;
  logic [31:0]     f_addr;
  logic [31:0]     lo_word;

  logic [15:0] c_sel  [NSEG];
  logic [31:0] c_base [NSEG];
  logic [31:0] c_lim  [NSEG];
  logic [1:0]  c_dpl  [NSEG];
  logic        c_ok   [NSEG];

  logic        ld_go, tr_go;
  logic [19:0] d_lim;
  logic [1:0]  cpl, rpl, eprv;
  logic        fault_c;
  logic [19:0] real_lin;
  logic [31:0] lin_c;

  assign ld_ready = (fst == F_IDLE);
  assign ld_go    = ld_valid && ld_ready;
  assign mem_req  = (fst != F_IDLE);
  assign mem_addr = f_addr + ((fst == F_HI) ? 32'd4 : 32'd0);
  assign tr_ready = !(mem_req && (f_seg == tr_seg));
  assign tr_go    = tr_valid && tr_ready;

  assign d_lim = {mem_rdata[19:16], lo_word[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst     <= F_IDLE;
      f_seg   <= '0;
      f_addr  <= '0;
      lo_word <= '0;
      for (int i = 0; i < NSEG; i++) begin
        c_sel[i]  <= '0;
        c_base[i] <= '0;
        c_lim[i]  <= '0;
        c_dpl[i]  <= '0;
        c_ok[i]   <= 1'b0;
      end
    end else begin
      case (fst)
        F_IDLE: if (ld_go) begin
          c_sel[ld_seg] <= ld_sel;
          if (!real_mode) begin
            fst    <= F_LO;
            f_seg  <= ld_seg;
            f_addr <= (ld_sel[2] ? ltab_base : gtab_base) + {16'd0, ld_sel[15:3], 3'b000};
          end
        end
        F_LO: if (mem_rvalid) begin
          lo_word <= mem_rdata;
          fst     <= F_HI;
        end
        F_HI: if (mem_rvalid) begin
          c_base[f_seg] <= {mem_rdata[31:24], mem_rdata[7:0], lo_word[31:16]};
          c_lim[f_seg]  <= mem_rdata[23] ? {d_lim, 12'hFFF} : {12'd0, d_lim};
          c_dpl[f_seg]  <= mem_rdata[14:13];
          c_ok[f_seg]   <= mem_rdata[15];
          fst           <= F_IDLE;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign cpl  = c_sel[0][1:0];
  assign rpl  = c_sel[tr_seg][1:0];
  assign eprv = (cpl > rpl) ? cpl : rpl;

  assign fault_c  = !real_mode &&
                    (!c_ok[tr_seg] || (tr_off > c_lim[tr_seg]) || (eprv > c_dpl[tr_seg]));
  assign real_lin = {c_sel[tr_seg], 4'h0} + {4'h0, tr_off[15:0]};
  assign lin_c    = real_mode ? {12'd0, real_lin} : (c_base[tr_seg] + tr_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_lin   <= '0;
    end else begin
      out_valid <= tr_go;
      if (tr_go) begin
        out_fault <= fault_c;
        out_lin   <= fault_c ? 32'd0 : lin_c;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        real_mode,
  input logic        ld_valid,
  input logic        ld_ready,
  input logic        tr_valid,
  input logic        tr_ready,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic [31:0] mem_addr,
  input logic        out_valid,
  input logic        out_fault,
  input logic [31:0] out_lin
);

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R2

  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && !real_mode |=> mem_req); // R2

  AST_REAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && real_mode |=> ld_ready && !mem_req); // R11

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ld_ready); // R13

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_lin == 32'd0); // R12

  AST_REAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && tr_ready && real_mode |=> out_valid && !out_fault && out_lin[31:20] == 12'd0); // R11

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tr_valid && tr_ready) |=> !out_valid); // R4

endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        real_mode = 1'b0;
  logic [31:0] gtab_base = 32'h0, ltab_base = 32'h200;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tr_valid = 1'b0;
  logic        tr_ready;
  logic [1:0]  tr_seg = '0;
  logic [31:0] tr_off = '0;
  logic        out_valid;
  logic [31:0] out_lin;
  logic        out_fault;

  always #10 clk = ~clk;

  seg_xlate uut (.*);

  int checks = 0, fails = 0, rd_cnt = 0;
  logic [31:0] mem [256];
  logic [31:0] rd_log [$];
  logic [31:0] q_lin [$];
  logic        q_flt [$];
  string       q_tag [$];

  always @(negedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[9:2]];
  end

  always @(posedge clk)
    if (rst_n && mem_req && mem_rvalid) begin
      rd_cnt++;
      rd_log.push_back(mem_addr);
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (q_lin.size() == 0) chk("R4 unexpected result", 32'd1, 32'd0);
      else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " lin"}, out_lin, q_lin.pop_front());
        chk({t, " fault"}, {31'd0, out_fault}, {31'd0, q_flt.pop_front()});
      end
    end

  task automatic put_desc(int w, logic [31:0] b, logic [19:0] l, bit g, logic [1:0] d, bit p);
    mem[w]   = {b[15:0], l[15:0]};
    mem[w+1] = {b[31:24], g, 1'b1, 2'b00, l[19:16], p, d, 1'b1, 4'h2, b[23:16]};
  endtask

  task automatic do_load(logic [1:0] s, logic [15:0] sel, bit wait_done);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 1'b0;
    if (wait_done) while (!ld_ready) @(negedge clk);
  endtask

  task automatic xl(logic [1:0] s, logic [31:0] off, logic [31:0] lin, bit flt, string tag);
    @(negedge clk);
    tr_valid = 1'b1; tr_seg = s; tr_off = off;
    while (!tr_ready) @(negedge clk);
    q_lin.push_back(flt ? 32'd0 : lin);
    q_flt.push_back(flt);
    q_tag.push_back(tag);
    @(negedge clk);
    tr_valid = 1'b0;
  endtask

  task automatic chk_reads(string tag, logic [31:0] a0);
    chk({tag, " read count"}, rd_log.size(), 2);
    if (rd_log.size() == 2) begin
      chk({tag, " first addr"}, rd_log[0], a0);
      chk({tag, " second addr"}, rd_log[1], a0 + 4);
    end
    rd_log.delete();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int n;
    foreach (mem[i]) mem[i] = '0;
    put_desc(2, 32'h1000_0000, 20'h00FFF, 0, 2'd0, 1);
    put_desc(4, 32'h0012_3400, 20'h00003, 1, 2'd3, 1);
    put_desc(6, 32'h2000_0000, 20'hFFFFF, 0, 2'd0, 0);
    put_desc(8'h82, 32'hAB12_3456, 20'hFFFFF, 0, 2'd0, 1);
    put_desc(8'h44, 32'h0055_0000, 20'h00010, 0, 2'd3, 1);

    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 ld_ready", {31'd0, ld_ready}, 1);
    chk("R1 tr_ready", {31'd0, tr_ready}, 1);
    rst_n = 1'b1;

    do_load(0, 16'h0008, 1);
    chk_reads("R2 global", 32'h8);
    xl(0, 32'h10,   32'h1000_0010, 0, "R4");
    xl(0, 32'hFFF,  32'h1000_0FFF, 0, "R5 at limit");
    xl(0, 32'h1000, 0, 1, "R5 past limit R12");

    do_load(1, 16'h0010, 1);
    chk_reads("R2 global idx2", 32'h10);
    xl(1, 32'h3FFF, 32'h0012_73FF, 0, "R6 at limit");
    xl(1, 32'h4000, 0, 1, "R6 past limit");

    do_load(2, 16'h000C, 1);
    chk_reads("R2 local", 32'h208);
    xl(2, 32'h5, 32'hAB12_345B, 0, "R3 split base");

    xl(3, 32'h0, 0, 1, "R7 never loaded");
    do_load(3, 16'h0018, 1);
    rd_log.delete();
    xl(3, 32'h0, 0, 1, "R7 not present");

    do_load(0, 16'h000B, 1);
    xl(2, 32'h0, 0, 1, "R8 cpl3 vs dpl0");
    xl(1, 32'h0, 32'h0012_3400, 0, "R8 cpl3 vs dpl3");
    xl(0, 32'h0, 0, 1, "R8 own register");
    do_load(0, 16'h0008, 1);
    do_load(2, 16'h000F, 1);
    xl(2, 32'h0, 0, 1, "R8 rpl3 vs dpl0");
    do_load(2, 16'h000C, 1);
    rd_log.delete();

    gtab_base = 32'h100;
    n = rd_cnt;
    xl(1, 32'h10, 32'h0012_3410, 0, "R9 stale base kept");
    xl(0, 32'h4, 32'h1000_0004, 0, "R9 stale base kept");
    repeat (2) @(negedge clk);
    chk("R9 no reads on translate", rd_cnt, n);

    do_load(1, 16'h0010, 0);
    tr_seg = 2'd1; #1;
    chk("R10 busy register stalls", {31'd0, tr_ready}, 0);
    chk("R13 ld_ready low in fetch", {31'd0, ld_ready}, 0);
    tr_seg = 2'd2; #1;
    chk("R10 other register ready", {31'd0, tr_ready}, 1);
    xl(2, 32'h1, 32'hAB12_3457, 0, "R10 pass during fetch");
    xl(1, 32'h8, 32'h0055_0008, 0, "R9 reload takes effect R10");
    xl(1, 32'h11, 0, 1, "R9 new limit");
    chk_reads("R2 new base", 32'h110);

    real_mode = 1'b1;
    n = rd_cnt;
    do_load(0, 16'hF000, 0);
    #1;
    chk("R11 load immediate", {31'd0, ld_ready}, 1);
    xl(0, 32'hFFF0, 32'h000F_FFF0, 0, "R11 top");
    do_load(1, 16'hFFFF, 1);
    xl(1, 32'h20, 32'h0000_0010, 0, "R11 wrap");
    do_load(2, 16'h1000, 1);
    xl(2, 32'h1234_0005, 32'h0001_0005, 0, "R11 high offset ignored");
    xl(3, 32'hFFFF_FFFF, 32'h0001_017F, 0, "R11 no fault");
    repeat (3) @(negedge clk);
    chk("R11 no reads", rd_cnt, n);
    chk("R4 all results seen", q_lin.size(), 0);
    summary();
  end

endmodule